// File: doc/BRIEF.md
# Flash Programming Control Register

This block is a single special-function register that sits on the internal register bus of an 8-bit microcontroller core. It decides when the flash controller may program bytes or run a mass erase. It holds a byte-program enable. While that enable is set, the core's external-data move instruction writes program flash at the data pointer address instead of data memory. The register also holds a mass-erase arm bit, a sticky security bit and a read-only boot-in-progress flag.

Each bit follows its own rule. The byte-program enable drops by itself after every completed flash byte, and software cannot change it while interrupts are globally enabled. The mass-erase arm can be written but not read back, and it disarms when an erase finishes, so each erase needs a fresh write. The security bit can only be set; after that only a reset clears it. While it is set, it blocks external readout of flash and of coprocessor program RAM. Reset is synchronous and active low.

Top module: `flash_ctl_reg`

## Requirements
- R1: During and after reset all three enable outputs are 0, and a read of the register returns only the boot flag in bit 7.
- R2: A write strobe at address `REG_ADDR` while `irq_global_en` is 0 loads `wdata[0]` into `prog_en` on the next clock edge; writes to any other address change no output.
- R3: While `irq_global_en` is 1, a write leaves `prog_en` unchanged. Bits 1 and 6 of the same write still take effect.
- R4: A `byte_done` pulse clears `prog_en` on the next edge, and it wins over a write in the same cycle.
- R5: A write loads `wdata[1]` into `erase_arm` whatever the state of `irq_global_en`. An `erase_done` pulse clears it on the next edge and wins over a write in the same cycle.
- R6: A write with `wdata[6]`=1 sets `secure`. A write with `wdata[6]`=0 does not clear it; only reset does.
- R7: With `sfr_rd` high and the address matching, `sfr_rdata` shows `boot_busy` in bit 7, `secure` in bit 6 and `prog_en` in bit 0 in the same cycle. Bit 1 reads 0. With no matching read, `sfr_rdata` is 0.
- R8: Writes to bits 2 to 5 and bit 7 have no effect. Those bits always read 0, except bit 7, which tracks `boot_busy` only.

Top module port list:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sfr_addr | input | ADDR_W | Register bus address |
| sfr_wr | input | 1 | Write strobe |
| sfr_rd | input | 1 | Read strobe |
| sfr_wdata | input | 8 | Write data |
| sfr_rdata | output | 8 | Read data, combinational |
| irq_global_en | input | 1 | Global interrupt enable of the core |
| byte_done | input | 1 | Pulse: one flash byte finished programming |
| erase_done | input | 1 | Pulse: mass erase finished |
| boot_busy | input | 1 | Boot sequence active |
| prog_en | output | 1 | Byte-program enable to the flash controller |
| erase_arm | output | 1 | Mass-erase enable to the flash controller |
| secure | output | 1 | Readout protection |

## Verification
A reference model runs random writes, reads and completion pulses, biased towards the register address and with the interrupt enable toggling. This mix separates the interrupt-gated bit from the ungated ones and catches a decode that ignores the address. Directed sequences then target the collisions: a completion pulse in the same cycle as a write that would set the bit, which shows the clear-wins ordering. A zero written over a set security bit, which tells a sticky bit from a plain one. Writes to the reserved bits and to the boot flag, which must never show up on readback.

// File: rtl/flash_ctl_pkg.sv
package flash_ctl_pkg;
   // Field positions the core's software decodes
   localparam int BIT_PROG   = 0;
   localparam int BIT_ERASE  = 1;
   localparam int BIT_SECURE = 6;
   localparam int BIT_BOOT   = 7;
   localparam int SFR_W      = 8;
   typedef logic [SFR_W-1:0] sfr_byte_t;
endpackage

// File: rtl/flash_ctl_decode.sv
module flash_ctl_decode #(
   parameter int ADDR_W = 8,
   parameter logic [ADDR_W-1:0] REG_ADDR = '0
) (
   input  logic [ADDR_W-1:0] sfr_addr,
   input  logic              sfr_wr,
   input  logic              sfr_rd,
   output logic              hit_wr,
   output logic              hit_rd
);
   logic sel;
   assign sel    = (sfr_addr == REG_ADDR);
   assign hit_wr = sfr_wr && sel;
   assign hit_rd = sfr_rd && sel;
endmodule

// File: rtl/flash_ctl_clrbit.sv
module flash_ctl_clrbit (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_stb,
   input  logic wr_allow,
   input  logic wr_val,
   input  logic clr_pulse,
   output logic q
);
   always_ff @(posedge clk) begin
      if (!rst_n)                q <= 1'b0;
      else if (clr_pulse)        q <= 1'b0;
      else if (wr_stb && wr_allow) q <= wr_val;
   end

   // R4 R5: a completion pulse always leaves the bit cleared
   clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_pulse |=> !q);

   // R3: a blocked write does not move the bit
   blocked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_pulse && !(wr_stb && wr_allow)) |=> $stable(q));
endmodule

// File: rtl/flash_ctl_sticky.sv
module flash_ctl_sticky (
   input  logic clk,
   input  logic rst_n,
   input  logic set_stb,
   output logic q
);
   always_ff @(posedge clk) begin
      if (!rst_n)       q <= 1'b0;
      else if (set_stb) q <= 1'b1;
   end

   // R6
   sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      q |=> q);
endmodule

// File: rtl/flash_ctl_reg.sv
module flash_ctl_reg
   import flash_ctl_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter logic [ADDR_W-1:0] REG_ADDR = ADDR_W'(8'hB2),
   parameter bit ERASE_AUTO_CLEAR = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] sfr_addr,
   input  logic              sfr_wr,
   input  logic              sfr_rd,
   input  logic [7:0]        sfr_wdata,
   output logic [7:0]        sfr_rdata,
   input  logic              irq_global_en,
   input  logic              byte_done,
   input  logic              erase_done,
   input  logic              boot_busy,
   output logic              prog_en,
   output logic              erase_arm,
   output logic              secure
);
   generate
      if (ADDR_W < 1 || ADDR_W > 16) begin : g_bad_addr
         $error("flash_ctl_reg: ADDR_W out of range");
      end
      if (SFR_W != 8) begin : g_bad_width
         $error("flash_ctl_reg: register must be one byte");
      end
   endgenerate

   logic hit_wr, hit_rd;
   logic erase_clr;
   logic unused_wbits;

   assign unused_wbits = ^{sfr_wdata[7], sfr_wdata[5:2]};

   flash_ctl_decode #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_dec (
      .sfr_addr(sfr_addr), .sfr_wr(sfr_wr), .sfr_rd(sfr_rd),
      .hit_wr(hit_wr), .hit_rd(hit_rd));

   flash_ctl_clrbit u_prog (
      .clk(clk), .rst_n(rst_n), .wr_stb(hit_wr), .wr_allow(!irq_global_en),
      .wr_val(sfr_wdata[BIT_PROG]), .clr_pulse(byte_done), .q(prog_en));

   generate
      if (ERASE_AUTO_CLEAR) begin : g_erase_autoclr
         assign erase_clr = erase_done;
      end else begin : g_erase_manual
         logic unused_done;
         assign unused_done = erase_done;
         assign erase_clr   = 1'b0;
      end
   endgenerate

   flash_ctl_clrbit u_erase (
      .clk(clk), .rst_n(rst_n), .wr_stb(hit_wr), .wr_allow(1'b1),
      .wr_val(sfr_wdata[BIT_ERASE]), .clr_pulse(erase_clr), .q(erase_arm));

   flash_ctl_sticky u_sec (
      .clk(clk), .rst_n(rst_n), .set_stb(hit_wr && sfr_wdata[BIT_SECURE]),
      .q(secure));

   always_comb begin
      sfr_rdata = '0;
      if (hit_rd) begin
         sfr_rdata[BIT_BOOT]   = boot_busy;
         sfr_rdata[BIT_SECURE] = secure;
         sfr_rdata[BIT_PROG]   = prog_en;
      end
   end

   // R7: the write-only arm bit never appears on readback
   erase_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
      erase_arm |-> !sfr_rdata[BIT_ERASE]);

   // R8: reserved bits read zero
   reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sfr_rdata[5:2] == 4'b0000);

   // R2: program enable only rises after a decoded write
   prog_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(prog_en) |-> $past(hit_wr && !irq_global_en));
endmodule

// File: tb/flash_ctl_reg_tb_top.sv
module flash_ctl_reg_tb_top;
   localparam logic [7:0] A = 8'hB2;
   logic clk = 1'b0;
   logic rst_n;
   logic [7:0] sfr_addr, sfr_wdata, sfr_rdata;
   logic sfr_wr, sfr_rd, irq_global_en, byte_done, erase_done, boot_busy;
   logic prog_en, erase_arm, secure;
   int errors = 0, checks = 0;
   logic m_prog, m_erase, m_sec;

   always #4 clk = ~clk;

   flash_ctl_reg dut_i (.*);

   initial begin
      #1600000;
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_rd(input logic [7:0] ad, input logic rd);
      return (rd && ad == A) ? {boot_busy, m_sec, 4'b0, 1'b0, m_prog} : 8'h00;
   endfunction

   // drive one cycle, check read path, advance model, check outputs
   task automatic cyc(input logic [7:0] ad, input logic wr, input logic rd,
                      input logic [7:0] wd, input logic ie, input logic bd,
                      input logic ed, input logic bb);
      sfr_addr = ad; sfr_wr = wr; sfr_rd = rd; sfr_wdata = wd;
      irq_global_en = ie; byte_done = bd; erase_done = ed; boot_busy = bb;
      #2;
      chk("R7 R8 readback", sfr_rdata, exp_rd(ad, rd));
      @(posedge clk);
      if (!rst_n) begin m_prog = 0; m_erase = 0; m_sec = 0; end
      else begin
         if (bd) m_prog = 0; else if (wr && ad == A && !ie) m_prog = wd[0];
         if (ed) m_erase = 0; else if (wr && ad == A) m_erase = wd[1];
         if (wr && ad == A && wd[6]) m_sec = 1;
      end
      #1;
      chk("R2 R3 R4 prog_en", {7'b0, prog_en}, {7'b0, m_prog});
      chk("R5 erase_arm", {7'b0, erase_arm}, {7'b0, m_erase});
      chk("R6 secure", {7'b0, secure}, {7'b0, m_sec});
   endtask

   initial begin
      void'($urandom(32'h5EED));
      m_prog = 0; m_erase = 0; m_sec = 0;
      rst_n = 1'b0;
      @(posedge clk); #1;
      cyc(A, 1, 0, 8'hFF, 0, 0, 0, 1);       // R1: write during reset ignored
      cyc(A, 0, 1, 8'h00, 0, 0, 0, 1);
      chk("R1 reset outputs", {5'b0, prog_en, erase_arm, secure}, 8'h00);
      rst_n = 1'b1;
      cyc(A, 0, 1, 8'h00, 0, 0, 0, 1);       // R1: read shows only boot flag
      chk("R1 reset readback", sfr_rdata, 8'h80);
      // R2: wrong address ignored, right address loads
      cyc(8'hB3, 1, 0, 8'h03, 0, 0, 0, 0);
      cyc(A, 1, 0, 8'h03, 0, 0, 0, 0);
      // R3: with interrupts on, prog clear blocked but erase bit taken
      cyc(A, 1, 0, 8'h00, 1, 0, 0, 0);
      chk("R3 prog held", {7'b0, prog_en}, 8'h01);
      // R4: byte_done wins over set
      cyc(A, 1, 0, 8'h01, 0, 1, 0, 0);
      chk("R4 clear wins", {7'b0, prog_en}, 8'h00);
      // R5: erase_done wins over arm write
      cyc(A, 1, 0, 8'h02, 1, 0, 0, 0);
      cyc(A, 1, 0, 8'h02, 0, 0, 1, 0);
      chk("R5 erase clear wins", {7'b0, erase_arm}, 8'h00);
      // R6: set then try to clear
      cyc(A, 1, 0, 8'h40, 0, 0, 0, 0);
      cyc(A, 1, 1, 8'h00, 0, 0, 0, 0);
      chk("R6 sticky", {7'b0, secure}, 8'h01);
      // R8: reserved bits and boot flag written, readback shows none
      cyc(A, 1, 0, 8'hBC, 0, 0, 0, 0);
      cyc(A, 0, 1, 8'h00, 0, 0, 0, 0);
      chk("R8 reserved read", sfr_rdata, 8'h40);
      // random mix
      for (int i = 0; i < 400; i++) begin
         logic [7:0] ad;
         ad = ($urandom % 4 != 0) ? A : 8'($urandom);
         if (i == 200) begin
            rst_n = 1'b0;
            cyc(A, 0, 0, 8'h00, 0, 0, 0, 0);
            rst_n = 1'b1;
         end
         cyc(ad, 1'($urandom), 1'($urandom), 8'($urandom), 1'($urandom),
             ($urandom % 6 == 0), ($urandom % 6 == 0), 1'($urandom));
      end
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule